// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and a calendar in packed BCD bytes and advances them by one second on each pulse of a one-per-second tick. The count covers seconds and minutes, hours in a 24-hour or 12-hour form, a day-of-week counter and a date/month/year calendar. Month lengths follow the calendar, and February has 29 days in years divisible by four.

A host loads and inspects every register over a simple parallel bus. Writes are synchronous with a 4-bit address. Reads are combinational through a separate read address. A time-of-day alarm compares four fields (seconds, minutes, hours and day of week) against the time just reached. Each alarm field has its own mask bit, so the same comparator gives alarms once a second, once a minute, hourly, daily or weekly. A match latches a status flag. The flag drives an active-high interrupt while the interrupt enable is set.

Top module: `rtc_calendar`

## Requirements
- R1: After reset the clock reads 00:00:00 in 24-hour form, day of week 1, date 01, month 01, year 00. All alarm bytes, the control byte and the status byte read 0, and `irq_o` is low.
- R2: Seconds (address 0x0) and minutes (address 0x1) count 00 to 59 in BCD. On the tick that takes seconds from 59 to 00, minutes advance. On the tick that takes both seconds and minutes to 00, the hour advances.
- R3: With hours-byte (address 0x2) bit 6 at 0, bits 5:0 count 00 to 23 in BCD. The change from 23 to 00 carries into the day.
- R4: With hours-byte bit 6 at 1, bit 5 is PM (1 = PM) and bits 4:0 count 12, 01 ... 11 in BCD. The PM bit toggles on the change from 11 to 12. The day advances only on the change from 11 PM to 12 AM.
- R5: Day of week (address 0x3, bits 2:0) counts 1 to 7 and returns to 1 on a day carry.
- R6: On a day carry, the date (0x4) goes to 01 after the last day of the month and carries into the month. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the BCD year (0x6) is divisible by 4 and 28 days otherwise. All other months have 31 days. Month (0x5) goes from 12 to 01 and carries into the year. The year goes from 99 to 00.
- R7: While control byte (0xC) bit 7 is 1, ticks leave every time and calendar register unchanged.
- R8: Alarm bytes for seconds, minutes, hours and day of week sit at 0x8, 0x9, 0xA and 0xB. Bit 7 of each alarm byte masks that field. On an applied tick, the status flag (0xD bit 0) is set when every unmasked field equals the time just reached. The hours compare uses bits 6:0 and the day compare uses bits 2:0.
- R9: `irq_o` is high exactly while the status flag and control bit 0 are both 1.
- R10: Any host write to address 0xD clears the status flag.
- R11: Bits with no function read 0 whatever is written. Hour and time bytes have bit 7 at 0, date has bits 7:6 at 0, month has bits 7:5 at 0, the day-of-week alarm has bits 6:3 at 0, and the control byte has bits 6:1 at 0. Addresses 0x7, 0xE and 0xF read 0.
- R12: A tick in the same cycle as any host write is dropped. The written value is kept and no register advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 4 | Host write address |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 4 | Host read address |
| rd_data_o | output | 8 | Read data, combinational from `rd_addr_i` |
| irq_o | output | 1 | Alarm interrupt, active high |

## Verification
The assertions check, on every cycle, the register-level invariants:
- the seconds wrap;
- the 24-hour midnight wrap;
- the PM toggle;
- the day-of-week wrap;
- the freeze of all time registers whenever no tick is applied;
- the flag being set on a match and cleared by a status write;
- the interrupt holding steady between host writes.

Only the bench scenarios can show the calendar results, because each one must be driven to a precise instant:
- month-end rollover in 30-day months, 31-day months and February, in leap and ordinary years;
- the century wrap from 99 to 00;
- each alarm mask pattern firing on exactly the right tick;
- the dropped tick when a tick coincides with a host write.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned N_ALM  = 4;

  typedef logic [BYTE_W-1:0] bcd8_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_SEC  = 4'h0;
  localparam addr_t A_MIN  = 4'h1;
  localparam addr_t A_HOUR = 4'h2;
  localparam addr_t A_DOW  = 4'h3;
  localparam addr_t A_DATE = 4'h4;
  localparam addr_t A_MON  = 4'h5;
  localparam addr_t A_YEAR = 4'h6;
  localparam addr_t A_ALM0 = 4'h8;  // alarm sec, min, hour, dow follow
  localparam addr_t A_CTRL = 4'hC;
  localparam addr_t A_STAT = 4'hD;

  localparam bcd8_t M_SEC  = 8'h7F;
  localparam bcd8_t M_HOUR = 8'h7F;
  localparam bcd8_t M_DOW  = 8'h07;
  localparam bcd8_t M_DATE = 8'h3F;
  localparam bcd8_t M_MON  = 8'h1F;
  localparam bcd8_t M_CTRL = 8'h81;
  localparam bcd8_t M_ADOW = 8'h87;

  function automatic bcd8_t bcd_inc(bcd8_t v);
    return (v[3:0] >= 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(bcd8_t y);
    logic lo_a, lo_b;
    lo_a = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    lo_b = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? lo_b : lo_a;
  endfunction

  function automatic bcd8_t month_len(bcd8_t m, bcd8_t y);
    case (m)
      8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_cal_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  adv_i,
  input  logic  wr_en_i,
  input  addr_t wr_addr_i,
  input  bcd8_t wr_data_i,
  output bcd8_t sec_o,
  output bcd8_t min_o,
  output bcd8_t hour_o,
  output bcd8_t dow_o,
  output bcd8_t date_o,
  output bcd8_t mon_o,
  output bcd8_t year_o,
  output bcd8_t sec_n_o,
  output bcd8_t min_n_o,
  output bcd8_t hour_n_o,
  output bcd8_t dow_n_o
);
  bcd8_t sec_q, min_q, hour_q, dow_q, date_q, mon_q, year_q;
  bcd8_t sec_d, min_d, hour_d, dow_d, date_d, mon_d, year_d;
  bcd8_t hr_inc, h_tmp;
  logic  sec_wrap, min_wrap, day_c, date_wrap, mon_wrap;
  logic  c_min, c_hr, c_day, c_mon, c_yr;

  always_comb begin
    sec_wrap  = sec_q >= 8'h59;
    min_wrap  = min_q >= 8'h59;
    date_wrap = date_q >= month_len(mon_q, year_q);
    mon_wrap  = mon_q >= 8'h12;
    day_c     = 1'b0;
    h_tmp     = '0;
    if (hour_q[6]) begin
      if (hour_q[4:0] == 5'h11) begin
        hr_inc = {2'b01, ~hour_q[5], 5'h12};
        day_c  = hour_q[5];  // 11 PM -> 12 AM
      end else if (hour_q[4:0] >= 5'h12) begin
        hr_inc = {2'b01, hour_q[5], 5'h01};
      end else begin
        h_tmp  = bcd_inc({3'b000, hour_q[4:0]});
        hr_inc = {2'b01, hour_q[5], h_tmp[4:0]};
      end
    end else if (hour_q[5:0] >= 6'h23) begin
      hr_inc = 8'h00;
      day_c  = 1'b1;
    end else begin
      h_tmp  = bcd_inc({2'b00, hour_q[5:0]});
      hr_inc = {2'b00, h_tmp[5:0]};
    end

    c_min = adv_i & sec_wrap;
    c_hr  = c_min & min_wrap;
    c_day = c_hr & day_c;
    c_mon = c_day & date_wrap;
    c_yr  = c_mon & mon_wrap;

    sec_d  = adv_i ? (sec_wrap ? 8'h00 : bcd_inc(sec_q)) : sec_q;
    min_d  = c_min ? (min_wrap ? 8'h00 : bcd_inc(min_q)) : min_q;
    hour_d = c_hr  ? hr_inc : hour_q;
    dow_d  = c_day ? ((dow_q >= 8'h07) ? 8'h01 : dow_q + 8'h01) : dow_q;
    date_d = c_day ? (date_wrap ? 8'h01 : bcd_inc(date_q)) : date_q;
    mon_d  = c_mon ? (mon_wrap ? 8'h01 : bcd_inc(mon_q)) : mon_q;
    year_d = c_yr  ? ((year_q >= 8'h99) ? 8'h00 : bcd_inc(year_q)) : year_q;

    if (wr_en_i) begin
      case (wr_addr_i)
        A_SEC:  sec_d  = wr_data_i & M_SEC;
        A_MIN:  min_d  = wr_data_i & M_SEC;
        A_HOUR: hour_d = wr_data_i & M_HOUR;
        A_DOW:  dow_d  = wr_data_i & M_DOW;
        A_DATE: date_d = wr_data_i & M_DATE;
        A_MON:  mon_d  = wr_data_i & M_MON;
        A_YEAR: year_d = wr_data_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q <= 8'h00; min_q <= 8'h00; hour_q <= 8'h00; dow_q <= 8'h01;
      date_q <= 8'h01; mon_q <= 8'h01; year_q <= 8'h00;
    end else begin
      sec_q <= sec_d; min_q <= min_d; hour_q <= hour_d; dow_q <= dow_d;
      date_q <= date_d; mon_q <= mon_d; year_q <= year_d;
    end
  end

  assign sec_o    = sec_q;
  assign min_o    = min_q;
  assign hour_o   = hour_q;
  assign dow_o    = dow_q;
  assign date_o   = date_q;
  assign mon_o    = mon_q;
  assign year_o   = year_q;
  assign sec_n_o  = sec_d;
  assign min_n_o  = min_d;
  assign hour_n_o = hour_d;
  assign dow_n_o  = dow_d;

  p_sec_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && sec_q == 8'h59) |=> (sec_q == 8'h00 && min_q != $past(min_q)));

  p_midnight_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && sec_q == 8'h59 && min_q == 8'h59 && hour_q == 8'h23)
    |=> (hour_q == 8'h00));

  p_pm_toggle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wr_en_i && sec_q == 8'h59 && min_q == 8'h59 && hour_q[6] && hour_q[4:0] == 5'h11)
    |=> (hour_q[5] != $past(hour_q[5]) && hour_q[4:0] == 5'h12));

  p_dow_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (c_day && !wr_en_i && dow_q == 8'h07) |=> (dow_q == 8'h01));

  // R7 and R12: no applied tick and no write keeps every register
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !wr_en_i) |=> ($stable(sec_q) && $stable(min_q) && $stable(hour_q) &&
      $stable(dow_q) && $stable(date_q) && $stable(mon_q) && $stable(year_q)));
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match
  import rtc_cal_pkg::*;
(
  input  logic                    adv_i,
  input  logic [N_ALM-1:0][7:0]   alm_i,
  input  logic [N_ALM-1:0][7:0]   now_i,
  output logic                    hit_o
);
  localparam logic [N_ALM-1:0][7:0] CMP_M = {M_DOW, M_HOUR, M_SEC, M_SEC};
  logic [N_ALM-1:0] fld_ok;

  for (genvar i = 0; i < N_ALM; i++) begin : g_fld
    assign fld_ok[i] = alm_i[i][7] | ((alm_i[i] & CMP_M[i]) == (now_i[i] & CMP_M[i]));
  end

  assign hit_o = adv_i & (&fld_ok);
endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtc_cal_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       wr_en_i,
  input  logic [3:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] rd_addr_i,
  output logic [7:0] rd_data_o,
  output logic       irq_o
);
  logic [N_ALM-1:0][7:0] alm_q, now_n;
  bcd8_t ctrl_q;
  logic  flag_q, adv, hit;
  bcd8_t sec, min, hour, dow, date, mon, year;

  // a write in the same cycle drops the tick
  assign adv = tick_i & ~ctrl_q[7] & ~wr_en_i;

  rtc_time_core u_core (
    .clk_i, .rst_ni, .adv_i(adv), .wr_en_i, .wr_addr_i, .wr_data_i,
    .sec_o(sec), .min_o(min), .hour_o(hour), .dow_o(dow),
    .date_o(date), .mon_o(mon), .year_o(year),
    .sec_n_o(now_n[0]), .min_n_o(now_n[1]), .hour_n_o(now_n[2]), .dow_n_o(now_n[3])
  );

  rtc_alarm_match u_alm (.adv_i(adv), .alm_i(alm_q), .now_i(now_n), .hit_o(hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        if (wr_addr_i[3:2] == A_ALM0[3:2])
          alm_q[wr_addr_i[1:0]] <= (wr_addr_i[1:0] == 2'd3) ? (wr_data_i & M_ADOW) : wr_data_i;
        if (wr_addr_i == A_CTRL) ctrl_q <= wr_data_i & M_CTRL;
      end
      if (hit) flag_q <= 1'b1;
      else if (wr_en_i && wr_addr_i == A_STAT) flag_q <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_SEC:         rd_data_o = sec;
      A_MIN:         rd_data_o = min;
      A_HOUR:        rd_data_o = hour;
      A_DOW:         rd_data_o = dow;
      A_DATE:        rd_data_o = date;
      A_MON:         rd_data_o = mon;
      A_YEAR:        rd_data_o = year;
      4'h8, 4'h9, 4'hA, 4'hB: rd_data_o = alm_q[rd_addr_i[1:0]];
      A_CTRL:        rd_data_o = ctrl_q;
      A_STAT:        rd_data_o = {7'b0, flag_q};
      default:       rd_data_o = 8'h00;
    endcase
  end

  assign irq_o = flag_q & ctrl_q[0];

  p_flag_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q);

  p_flag_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_STAT && !hit) |=> !flag_q);

  p_irq_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !wr_en_i) |=> irq_o);

  p_no_tick_on_wr_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && wr_en_i && wr_addr_i != A_SEC) |=> $stable(sec));
endmodule

// File: tb/rtc_calendar_test.sv
module rtc_calendar_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq;

  int checks = 0, fails = 0;
  bit done = 0;
  string tag = "R1";
  logic [3:0] rd_ptr = '0;

  // reference model state
  int s = 0, mi = 0, h24 = 0, dw = 1, dt = 1, mo = 1, yr = 0;
  bit mode12 = 0, flag = 0;
  logic [7:0] al [4] = '{default: 8'h00};
  logic [7:0] ctl = 8'h00;

  always #2 clk = ~clk;

  rtc_calendar uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction
  function automatic int from_bcd(logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction
  function automatic int dim(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction
  function automatic logic [7:0] hour_byte();
    int h12;
    if (!mode12) return to_bcd(h24);
    h12 = (h24 % 12 == 0) ? 12 : h24 % 12;
    return 8'h40 | (h24 >= 12 ? 8'h20 : 8'h00) | to_bcd(h12);
  endfunction
  function automatic logic [7:0] enc(logic [3:0] a);
    case (a)
      4'h0: return to_bcd(s);
      4'h1: return to_bcd(mi);
      4'h2: return hour_byte();
      4'h3: return 8'(dw);
      4'h4: return to_bcd(dt);
      4'h5: return to_bcd(mo);
      4'h6: return to_bcd(yr);
      4'h8, 4'h9, 4'hA, 4'hB: return al[a[1:0]];
      4'hC: return ctl;
      4'hD: return {7'b0, flag};
      default: return 8'h00;
    endcase
  endfunction
  function automatic string req_of(logic [3:0] a);
    case (a)
      4'h0, 4'h1: return "R2";
      4'h2: return mode12 ? "R4" : "R3";
      4'h3: return "R5";
      4'h4, 4'h5, 4'h6: return "R6";
      4'h8, 4'h9, 4'hA, 4'hB: return "R8";
      4'hC: return "R7";
      4'hD: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_write(logic [3:0] a, logic [7:0] d);
    case (a)
      4'h0: s = from_bcd(d & 8'h7F);
      4'h1: mi = from_bcd(d & 8'h7F);
      4'h2: begin
        mode12 = d[6];
        if (d[6]) h24 = (from_bcd(d & 8'h1F) % 12) + (d[5] ? 12 : 0);
        else      h24 = from_bcd(d & 8'h3F);
      end
      4'h3: dw = int'(d & 8'h07);
      4'h4: dt = from_bcd(d & 8'h3F);
      4'h5: mo = from_bcd(d & 8'h1F);
      4'h6: yr = from_bcd(d);
      4'h8, 4'h9, 4'hA: al[a[1:0]] = d;
      4'hB: al[3] = d & 8'h87;
      4'hC: ctl = d & 8'h81;
      4'hD: flag = 0;
      default: ;
    endcase
  endtask

  task automatic model_advance();
    bit ok;
    s++;
    if (s == 60) begin
      s = 0; mi++;
      if (mi == 60) begin
        mi = 0; h24++;
        if (h24 == 24) begin
          h24 = 0; dw = (dw == 7) ? 1 : dw + 1; dt++;
          if (dt > dim(mo, yr)) begin
            dt = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
          end
        end
      end
    end
    ok = 1;
    if (!al[0][7] && (al[0] & 8'h7F) != enc(4'h0)) ok = 0;
    if (!al[1][7] && (al[1] & 8'h7F) != enc(4'h1)) ok = 0;
    if (!al[2][7] && (al[2] & 8'h7F) != (enc(4'h2) & 8'h7F)) ok = 0;
    if (!al[3][7] && (al[3] & 8'h07) != 8'(dw)) ok = 0;
    if (ok) flag = 1;
  endtask

  task automatic cyc(bit tk, bit we, logic [3:0] wa, logic [7:0] wd);
    logic [7:0] exp;
    @(negedge clk);
    tick = tk; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = rd_ptr;
    #1;
    exp = enc(rd_ptr);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s [%s] addr=%0h got=%h exp=%h", req_of(rd_ptr), tag, rd_ptr, rd_data, exp);
    end
    checks++;
    if (irq !== (flag && ctl[0])) begin
      fails++;
      $display("FAIL R9 [%s] irq got=%b exp=%b", tag, irq, flag && ctl[0]);
    end
    @(posedge clk);
    if (we) model_write(wa, wd);
    else if (tk && !ctl[7]) model_advance();
    rd_ptr = rd_ptr + 4'd1;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 4'h0, 8'h00);
  endtask
  task automatic wr(logic [3:0] a, logic [7:0] d);
    cyc(0, 1, a, d);
  endtask
  task automatic tk(int n);
    for (int i = 0; i < n; i++) begin cyc(1, 0, 4'h0, 8'h00); idle(16); end
  endtask
  task automatic set_time(logic [7:0] ss, logic [7:0] mm, logic [7:0] hh, logic [7:0] ww,
                          logic [7:0] dd, logic [7:0] mn, logic [7:0] yy);
    wr(4'h0, ss); wr(4'h1, mm); wr(4'h2, hh); wr(4'h3, ww);
    wr(4'h4, dd); wr(4'h5, mn); wr(4'h6, yy);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";  idle(16);
    tag = "R2";  set_time(8'h58, 8'h59, 8'h05, 8'h02, 8'h10, 8'h03, 8'h21); tk(3);
    tag = "R3";  set_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23); tk(2);
    tag = "R6";  set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h28, 8'h02, 8'h24); tk(1);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24); tk(1);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h30, 8'h04, 8'h50); tk(1);
    set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h31, 8'h12, 8'h99); tk(1);
    tag = "R4";  set_time(8'h59, 8'h59, 8'h71, 8'h03, 8'h15, 8'h06, 8'h30); tk(1);
    set_time(8'h59, 8'h59, 8'h51, 8'h03, 8'h15, 8'h06, 8'h30); tk(1);
    set_time(8'h59, 8'h59, 8'h72, 8'h03, 8'h15, 8'h06, 8'h30); tk(1);
    tag = "R7";  wr(4'hC, 8'h80); tk(3); wr(4'hC, 8'h00); tk(1);
    tag = "R12"; cyc(1, 1, 4'h1, 8'h30); idle(16); cyc(1, 1, 4'h9, 8'h80); idle(16);
    tag = "R8";  wr(4'hC, 8'h01);
    wr(4'h8, 8'h80); wr(4'h9, 8'h80); wr(4'hA, 8'h80); wr(4'hB, 8'h80); tk(1);
    tag = "R9";  wr(4'hC, 8'h00); idle(4); wr(4'hC, 8'h01); idle(4);
    tag = "R10"; wr(4'hD, 8'h00); idle(16);
    tag = "R8";  wr(4'h0, 8'h02); wr(4'h8, 8'h05);
    for (int i = 0; i < 5; i++) begin tk(1); wr(4'hD, 8'h00); end
    set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h10, 8'h05, 8'h40);
    wr(4'h8, 8'h00); wr(4'h9, 8'h00); wr(4'hA, 8'h00); wr(4'hB, 8'h03); tk(1);
    wr(4'hD, 8'h00);
    set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h10, 8'h05, 8'h40); tk(1);
    tag = "R11"; wr(4'h0, 8'hD9); wr(4'h3, 8'hFF); wr(4'h4, 8'hE5); wr(4'h5, 8'hF1);
    wr(4'hB, 8'hFF); wr(4'hE, 8'hFF); wr(4'h7, 8'hFF); wr(4'hC, 8'hFE); idle(16);
    wr(4'hC, 8'h00); tk(1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog got=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule